// File: doc/BRIEF.md
# Moving-Cell Memory Transition Tester

This block is a built-in self-test engine for a banked, word-addressed memory with one port. It drives the memory directly through a synchronous interface: an enable, a write strobe, a bank number, a word address and write data. Read data comes back exactly one cycle after the read is issued. A one-cycle `start` pulse samples a lowest and a highest bank number. The engine then clears every word of those banks. After that it repeats a four-phase moving-cell sequence with no end. In each phase one target cell at a time is flipped against a uniform background.

For every target and every bank, the engine first reads from the target toward one end of the bank and checks the background. It then writes the complement into the target. Finally it reads from the target toward the other end and checks the complement. Across the four phases the target walks both up and down the address space, and the background is both all zeros and all ones. This catches cells that disturb, or are disturbed by, a neighbour in either direction of transition. Each completed set of four phases adds one to a pass counter.

When a read does not match, the engine logs a syndrome and reads the failing word a second time. It then stops with an error flag raised until the next `start`. The syndrome holds the bank, the word, the phase, the data read, the data re-read, and the wrong bits split into those that read 1 when 0 was expected and those that read 0 when 1 was expected.

Top module: `mcell_bist`

## Requirements
- R1: After reset `busy`, `error`, `mem_en` and `pass_count` are all 0, and no memory access takes place until `start` is pulsed.
- R2: A `start` pulse samples `low_bank` and `high_bank` (with low ≤ high). Phase 0 (`phase` = 0) then writes 0 to word 0 up to the top word of each bank, banks in ascending order, and is followed by phase 1.
- R3: Phase 1 (`phase` = 1) uses an all-zero background and phase 2 (`phase` = 2) an all-ones background. In both, the target walks from word 0 up to the top word.
- R4: In phases 1 and 2, for target T in one bank the engine reads T, T+1 … top and expects the background. It then writes the inverted background to T and reads T, T−1 … 0, expecting the inverted background.
- R5: Phase 3 (all-zero background) and phase 4 (all-ones background) walk the target from the top word down to 0. For target T the engine reads T down to 0 and expects the background. It then writes the inverted background to T and reads T up to the top, expecting the inverted background.
- R6: For each target, the read/write/read step runs in every bank from `low_bank` to `high_bank`, in ascending bank order, before the target moves. No access leaves that bank range.
- R7: When phase 4 ends, `pass_count` increases by exactly 1 and phase 1 restarts. Phase 0 does not run again.
- R8: Read data is compared in the cycle after the read is issued (fixed latency of one cycle). A fault-free memory never raises `error`.
- R9: On a mismatch, the engine logs the bank, the phase and the data read (`err_found`). It sets `err_diff` = found XOR expected, `err_picked` = diff AND NOT expected, and `err_dropped` = diff AND expected.
- R10: `err_addr` names the word whose read mismatched, in ascending and descending scans alike, even though the scan pointer has already moved on.
- R11: After a mismatch, the engine issues exactly one more read, to the failing word, and stores its data in `err_reread`. It then holds `error` = 1 and `busy` = 0 and makes no further memory access.
- R12: A `start` pulse clears `error` and `pass_count` at any time, running or halted, and the sequence begins again at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: sample bank range and begin at phase 0 |
| low_bank | input | BW | First bank to test |
| high_bank | input | BW | Last bank to test |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write (valid with `mem_en`) |
| mem_bank | output | BW | Bank of the access |
| mem_addr | output | AW | Word of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after a read |
| busy | output | 1 | Test sequence running |
| error | output | 1 | Halted on a mismatch |
| phase | output | 3 | Current phase code 0..4 |
| pass_count | output | PW | Completed passes of phases 1 to 4 |
| err_bank | output | BW | Bank of the failing word |
| err_addr | output | AW | Failing word |
| err_phase | output | 3 | Phase in which the failure occurred |
| err_found | output | DW | Data read at the failure |
| err_reread | output | DW | Data from the second read of the failing word |
| err_diff | output | DW | Found XOR expected |
| err_picked | output | DW | Bits read as 1 where 0 was expected |
| err_dropped | output | DW | Bits read as 0 where 1 was expected |

## Verification
The hardest case to reach is a failure that appears only after another cell has been flipped. Such a failure is caught in the middle of a scan, after the pointer has already moved past the failing word. The bench's memory model injects two kinds of fault. The first is a coupling fault, where a rising write to one cell sets a bit in a distant cell; it surfaces during the ascending scan of a later target. The second is a stuck-at-0 bit, which shows up only on the first read of the descending scan after the flip. Both are placed where phase 1 reaches them within a few targets. A long fault-free run in a bank range that does not start at zero is compared operation by operation against a model of the sequence built in the bench.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FILL, ST_SCAN_A, ST_FLIP, ST_SCAN_B,
    ST_NEXT, ST_REREAD, ST_CAPTURE, ST_HALT
  } state_e;

  // phase codes are visible on the phase/err_phase ports
  typedef enum logic [2:0] {
    PH_FILL   = 3'd0,
    PH_FWD_UP = 3'd1,
    PH_FWD_DN = 3'd2,
    PH_REV_UP = 3'd3,
    PH_REV_DN = 3'd4
  } phase_e;

  function automatic logic phase_reverse(phase_e p);
    return (p == PH_REV_UP) || (p == PH_REV_DN);
  endfunction

  function automatic logic phase_ones(phase_e p);
    return (p == PH_FWD_DN) || (p == PH_REV_DN);
  endfunction

  function automatic phase_e phase_after(phase_e p);
    case (p)
      PH_FWD_UP: return PH_FWD_DN;
      PH_FWD_DN: return PH_REV_UP;
      PH_REV_UP: return PH_REV_DN;
      default:   return PH_FWD_UP;
    endcase
  endfunction

endpackage

// File: rtl/mcell_seq.sv
module mcell_seq
  import mcell_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 2,
  parameter int DW = 8,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] low_bank,
  input  logic [BW-1:0] high_bank,
  input  logic          mismatch,
  input  logic [AW-1:0] fail_addr,
  output logic          op_en,
  output logic          op_we,
  output logic [BW-1:0] op_bank,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_wdata,
  output logic          rd_issue,
  output logic [DW-1:0] rd_exp,
  output logic          rd_dec,
  output logic [AW-1:0] scan_ptr,
  output logic          capture,
  output logic          busy,
  output logic          halted,
  output logic [2:0]    phase,
  output logic [PW-1:0] pass_count
);

  localparam logic [AW-1:0] ADDR_TOP = {AW{1'b1}};

  state_e        st;
  phase_e        ph;
  logic [AW-1:0] ptr, tgt;
  logic [BW-1:0] bank, lo_q, hi_q;
  logic [PW-1:0] pass_q;

  function automatic logic [AW-1:0] step_ptr(logic [AW-1:0] a, logic dec);
    return dec ? a - 1'b1 : a + 1'b1;
  endfunction

  // named events used by the next-state logic and the assertions
  logic          rev, kill, raw_en, raw_we, raw_issue;
  logic [DW-1:0] bg;
  logic [AW-1:0] end_a, end_b, last_tgt, next_tgt, first_tgt;

  assign rev       = phase_reverse(ph);
  assign bg        = {DW{phase_ones(ph)}};
  assign end_a     = rev ? '0 : ADDR_TOP;
  assign end_b     = rev ? ADDR_TOP : '0;
  assign last_tgt  = rev ? '0 : ADDR_TOP;
  assign next_tgt  = step_ptr(tgt, rev);
  assign first_tgt = phase_reverse(phase_after(ph)) ? ADDR_TOP : '0;
  assign kill      = mismatch | start;

  always_comb begin
    raw_en    = 1'b0;
    raw_we    = 1'b0;
    raw_issue = 1'b0;
    op_addr   = ptr;
    op_wdata  = ~bg;
    rd_exp    = bg;
    rd_dec    = rev;
    case (st)
      ST_FILL:   begin raw_en = 1'b1; raw_we = 1'b1; op_wdata = '0; end
      ST_SCAN_A: begin raw_en = 1'b1; raw_issue = 1'b1; end
      ST_FLIP:   begin raw_en = 1'b1; raw_we = 1'b1; op_addr = tgt; end
      ST_SCAN_B: begin raw_en = 1'b1; raw_issue = 1'b1; rd_exp = ~bg; rd_dec = ~rev; end
      ST_REREAD: raw_en = 1'b1;
      default:   ;
    endcase
  end

  assign op_en      = raw_en & ~kill;
  assign op_we      = raw_we & ~kill;
  assign rd_issue   = raw_issue & ~kill;
  assign op_bank    = bank;
  assign scan_ptr   = ptr;
  assign capture    = (st == ST_CAPTURE);
  assign busy       = (st != ST_IDLE) && (st != ST_HALT);
  assign halted     = (st == ST_HALT);
  assign phase      = ph;
  assign pass_count = pass_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ph     <= PH_FILL;
      ptr    <= '0;
      tgt    <= '0;
      bank   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      pass_q <= '0;
    end else if (start) begin
      st     <= ST_FILL;
      ph     <= PH_FILL;
      ptr    <= '0;
      tgt    <= '0;
      bank   <= low_bank;
      lo_q   <= low_bank;
      hi_q   <= high_bank;
      pass_q <= '0;
    end else if (mismatch) begin
      st  <= ST_REREAD;
      ptr <= fail_addr;
    end else begin
      case (st)
        ST_FILL: begin
          ptr <= ptr + 1'b1;
          if (ptr == ADDR_TOP) st <= ST_NEXT;
        end
        ST_SCAN_A: begin
          ptr <= step_ptr(ptr, rev);
          if (ptr == end_a) st <= ST_FLIP;
        end
        ST_FLIP: begin
          ptr <= tgt;
          st  <= ST_SCAN_B;
        end
        ST_SCAN_B: begin
          ptr <= step_ptr(ptr, ~rev);
          if (ptr == end_b) st <= ST_NEXT;
        end
        ST_NEXT: begin
          if (bank != hi_q) begin
            bank <= bank + 1'b1;
            if (ph == PH_FILL) begin
              ptr <= '0;
              st  <= ST_FILL;
            end else begin
              ptr <= tgt;
              st  <= ST_SCAN_A;
            end
          end else begin
            bank <= lo_q;
            st   <= ST_SCAN_A;
            if (ph == PH_FILL) begin
              ph  <= PH_FWD_UP;
              tgt <= '0;
              ptr <= '0;
            end else if (tgt != last_tgt) begin
              tgt <= next_tgt;
              ptr <= next_tgt;
            end else begin
              ph  <= phase_after(ph);
              tgt <= first_tgt;
              ptr <= first_tgt;
              if (ph == PH_REV_DN) pass_q <= pass_q + 1'b1;
            end
          end
        end
        ST_REREAD:  st <= ST_CAPTURE;
        ST_CAPTURE: st <= ST_HALT;
        default:    ;
      endcase
    end
  end

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && lo_q <= hi_q) |-> (op_bank >= lo_q && op_bank <= hi_q)); // R6
  AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !op_en); // R11
  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (pass_q == $past(pass_q) || pass_q == $past(pass_q) + 1'b1)); // R7

endmodule

// File: rtl/mcell_chk.sv
module mcell_chk #(
  parameter int AW = 8,
  parameter int BW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          issue,
  input  logic [DW-1:0] issue_exp,
  input  logic          issue_dec,
  input  logic [AW-1:0] issue_addr,
  input  logic [AW-1:0] ptr,
  input  logic [BW-1:0] bank,
  input  logic [2:0]    phase,
  input  logic [DW-1:0] rdata,
  input  logic          capture,
  output logic          mismatch,
  output logic [AW-1:0] fail_addr,
  output logic [BW-1:0] err_bank,
  output logic [AW-1:0] err_addr,
  output logic [2:0]    err_phase,
  output logic [DW-1:0] err_found,
  output logic [DW-1:0] err_reread,
  output logic [DW-1:0] err_diff,
  output logic [DW-1:0] err_picked,
  output logic [DW-1:0] err_dropped
);

  logic          chk_v, chk_dec;
  logic [DW-1:0] chk_exp;
  logic [AW-1:0] chk_addr;
  logic [DW-1:0] diff;

  // undo one pointer step taken in the scan direction
  function automatic logic [AW-1:0] back_ptr(logic [AW-1:0] a, logic dec);
    return dec ? a + 1'b1 : a - 1'b1;
  endfunction

  function automatic logic [DW-1:0] picked_bits(logic [DW-1:0] d, logic [DW-1:0] e);
    return d & ~e;
  endfunction

  function automatic logic [DW-1:0] dropped_bits(logic [DW-1:0] d, logic [DW-1:0] e);
    return d & e;
  endfunction

  assign diff      = rdata ^ chk_exp;
  assign mismatch  = chk_v && (diff != '0);
  assign fail_addr = back_ptr(ptr, chk_dec);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      chk_v       <= 1'b0;
      chk_dec     <= 1'b0;
      chk_exp     <= '0;
      chk_addr    <= '0;
      err_bank    <= '0;
      err_addr    <= '0;
      err_phase   <= '0;
      err_found   <= '0;
      err_reread  <= '0;
      err_diff    <= '0;
      err_picked  <= '0;
      err_dropped <= '0;
    end else begin
      chk_v    <= issue;
      chk_dec  <= issue_dec;
      chk_exp  <= issue_exp;
      chk_addr <= issue_addr;
      if (mismatch) begin
        err_bank    <= bank;
        err_addr    <= fail_addr;
        err_phase   <= phase;
        err_found   <= rdata;
        err_diff    <= diff;
        err_picked  <= picked_bits(diff, chk_exp);
        err_dropped <= dropped_bits(diff, chk_exp);
      end
      if (capture) err_reread <= rdata;
    end
  end

  AST_FAIL_ADDR_MATCHES_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> (fail_addr == chk_addr)); // R10

endmodule

// File: rtl/mcell_bist.sv
module mcell_bist #(
  parameter int AW = 8,
  parameter int BW = 2,
  parameter int DW = 8,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] low_bank,
  input  logic [BW-1:0] high_bank,
  output logic          mem_en,
  output logic          mem_we,
  output logic [BW-1:0] mem_bank,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          error,
  output logic [2:0]    phase,
  output logic [PW-1:0] pass_count,
  output logic [BW-1:0] err_bank,
  output logic [AW-1:0] err_addr,
  output logic [2:0]    err_phase,
  output logic [DW-1:0] err_found,
  output logic [DW-1:0] err_reread,
  output logic [DW-1:0] err_diff,
  output logic [DW-1:0] err_picked,
  output logic [DW-1:0] err_dropped
);

  logic          mismatch, rd_issue, rd_dec, capture;
  logic [AW-1:0] fail_addr, scan_ptr;
  logic [DW-1:0] rd_exp;

  mcell_seq #(.AW(AW), .BW(BW), .DW(DW), .PW(PW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .low_bank   (low_bank),
    .high_bank  (high_bank),
    .mismatch   (mismatch),
    .fail_addr  (fail_addr),
    .op_en      (mem_en),
    .op_we      (mem_we),
    .op_bank    (mem_bank),
    .op_addr    (mem_addr),
    .op_wdata   (mem_wdata),
    .rd_issue   (rd_issue),
    .rd_exp     (rd_exp),
    .rd_dec     (rd_dec),
    .scan_ptr   (scan_ptr),
    .capture    (capture),
    .busy       (busy),
    .halted     (error),
    .phase      (phase),
    .pass_count (pass_count)
  );

  mcell_chk #(.AW(AW), .BW(BW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start),
    .issue       (rd_issue),
    .issue_exp   (rd_exp),
    .issue_dec   (rd_dec),
    .issue_addr  (mem_addr),
    .ptr         (scan_ptr),
    .bank        (mem_bank),
    .phase       (phase),
    .rdata       (mem_rdata),
    .capture     (capture),
    .mismatch    (mismatch),
    .fail_addr   (fail_addr),
    .err_bank    (err_bank),
    .err_addr    (err_addr),
    .err_phase   (err_phase),
    .err_found   (err_found),
    .err_reread  (err_reread),
    .err_diff    (err_diff),
    .err_picked  (err_picked),
    .err_dropped (err_dropped)
  );

  AST_SYNDROME_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (err_diff != '0)); // R9

endmodule

// File: tb/tb_mcell_bist.sv
module tb_mcell_bist;

  localparam int AW = 4, BW = 2, DW = 8, PW = 16;
  localparam int NW = 1 << AW;
  localparam int TOPW = NW - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] low_bank = '0, high_bank = '0;
  logic          mem_en, mem_we, busy, error;
  logic [BW-1:0] mem_bank, err_bank;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [2:0]    phase, err_phase;
  logic [PW-1:0] pass_count;
  logic [DW-1:0] err_found, err_reread, err_diff, err_picked, err_dropped;

  always #4 clk = ~clk;

  mcell_bist #(.AW(AW), .BW(BW), .DW(DW), .PW(PW)) dut (.*);

  int tests = 0, fails = 0, cyc = 0;

  // ---------------- memory model with fault injection ----------------
  logic [DW-1:0] mem [0:3][0:NW-1];
  logic [DW-1:0] m_old, m_new;
  bit sa_on = 0; int sa_bank = 0, sa_addr = 0, sa_bit = 0; bit sa_val = 0;
  bit cp_on = 0; int cp_bank = 0, cp_aggr = 0, cp_vict = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        m_old = mem[mem_bank][mem_addr];
        m_new = mem_wdata;
        if (sa_on && mem_bank == sa_bank && mem_addr == sa_addr) m_new[sa_bit] = sa_val;
        mem[mem_bank][mem_addr] = m_new;
        if (cp_on && mem_bank == cp_bank && mem_addr == cp_aggr && !m_old[0] && m_new[0])
          mem[cp_bank][cp_vict][0] = 1'b1;
      end else begin
        m_new = mem[mem_bank][mem_addr];
        if (sa_on && mem_bank == sa_bank && mem_addr == sa_addr) m_new[sa_bit] = sa_val;
        mem_rdata <= m_new;
      end
    end
  end

  // ---------------- behavioural reference of the operation stream ----------------
  logic [14:0] q[$];
  logic [6:0]  last_op;
  bit          err_seen = 0;

  task automatic push_op(bit we, int b, int a, logic [7:0] d);
    q.push_back({we, 2'(b), 4'(a), d});
  endtask

  task automatic push_fill(int lo, int hi);
    for (int b = lo; b <= hi; b++)
      for (int a = 0; a <= TOPW; a++) push_op(1'b1, b, a, 8'h00);
  endtask

  task automatic push_pass(int lo, int hi);
    for (int p = 1; p <= 4; p++) begin
      bit rev = (p >= 3);
      logic [7:0] bg = (p == 2 || p == 4) ? 8'hFF : 8'h00;
      for (int k = 0; k <= TOPW; k++) begin
        int t = rev ? TOPW - k : k;
        for (int b = lo; b <= hi; b++) begin
          if (!rev) begin
            for (int a = t; a <= TOPW; a++) push_op(1'b0, b, a, 8'h00);
            push_op(1'b1, b, t, ~bg);
            for (int a = t; a >= 0; a--) push_op(1'b0, b, a, 8'h00);
          end else begin
            for (int a = t; a >= 0; a--) push_op(1'b0, b, a, 8'h00);
            push_op(1'b1, b, t, ~bg);
            for (int a = t; a <= TOPW; a++) push_op(1'b0, b, a, 8'h00);
          end
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && error) err_seen = 1'b1;
    if (rst_n && mem_en) begin
      last_op = {mem_we, mem_bank, mem_addr};
      if (q.size() > 0) begin
        logic [14:0] e;
        e = q.pop_front();
        tests++;
        if (mem_we !== e[14] || mem_bank !== e[13:12] || mem_addr !== e[11:8] ||
            (e[14] && mem_wdata !== e[7:0])) begin
          fails++;
          $display("FAIL R2/R3/R4/R5/R6 op: actual we=%0b bank=%0d addr=%0d data=%h expected we=%0b bank=%0d addr=%0d data=%h",
                   mem_we, mem_bank, mem_addr, mem_wdata, e[14], e[13:12], e[11:8], e[7:0]);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(int lo, int hi);
    @(negedge clk);
    low_bank  = BW'(lo);
    high_bank = BW'(hi);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_error(int max);
    for (int i = 0; i < max && error !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic check_halt_quiet(string req);
    int seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_en) seen++;
    end
    check_eq(req, "memory accesses while halted", seen, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R8 watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_eq("R1", "busy after reset", busy, 0);
    check_eq("R1", "error after reset", error, 0);
    check_eq("R1", "pass_count after reset", pass_count, 0);
    check_eq("R1", "mem_en after reset", mem_en, 0);

    // Run A: fault-free, banks 1..2, two full passes compared op by op (R2..R7)
    push_fill(1, 2);
    push_pass(1, 2);
    push_pass(1, 2);
    pulse_start(1, 2);
    check_eq("R2", "phase right after start", phase, 0);
    check_eq("R12", "busy right after start", busy, 1);
    for (int i = 0; i < 20000 && q.size() > 0; i++) @(negedge clk);
    check_eq("R2", "reference ops left unconsumed", q.size(), 0);
    repeat (3) @(negedge clk);
    check_eq("R7", "pass_count after two passes", pass_count, 2);
    check_eq("R7", "phase restarts at 1", phase, 1);
    check_eq("R8", "error seen on fault-free memory", err_seen, 0);

    // Run B: stuck-at-1 bit 3 at bank 1 word 5, restart mid-run (R12), ascending scan
    sa_on = 1; sa_bank = 1; sa_addr = 5; sa_bit = 3; sa_val = 1;
    pulse_start(0, 1);
    check_eq("R12", "pass_count cleared by restart", pass_count, 0);
    check_eq("R12", "phase after restart", phase, 0);
    wait_error(5000);
    check_eq("R11", "error raised", error, 1);
    check_eq("R11", "busy dropped", busy, 0);
    check_eq("R9", "err_bank", err_bank, 1);
    check_eq("R10", "err_addr ascending scan", err_addr, 5);
    check_eq("R9", "err_phase", err_phase, 1);
    check_eq("R9", "err_found", err_found, 8'h08);
    check_eq("R9", "err_diff", err_diff, 8'h08);
    check_eq("R9", "err_picked", err_picked, 8'h08);
    check_eq("R9", "err_dropped", err_dropped, 8'h00);
    check_eq("R11", "err_reread", err_reread, 8'h08);
    check_eq("R11", "last access is re-read of failing word", last_op, {1'b0, 2'd1, 4'd5});
    check_halt_quiet("R11");

    // Run C: stuck-at-0 bit 6 at bank 0 word 9, fails in descending scan after the flip
    sa_on = 1; sa_bank = 0; sa_addr = 9; sa_bit = 6; sa_val = 0;
    pulse_start(0, 0);
    check_eq("R12", "error cleared by restart", error, 0);
    wait_error(5000);
    check_eq("R10", "err_addr descending scan", err_addr, 9);
    check_eq("R9", "err_bank single bank", err_bank, 0);
    check_eq("R9", "err_found", err_found, 8'hBF);
    check_eq("R9", "err_diff", err_diff, 8'h40);
    check_eq("R9", "err_picked", err_picked, 8'h00);
    check_eq("R9", "err_dropped", err_dropped, 8'h40);
    check_eq("R11", "err_reread", err_reread, 8'hBF);

    // Run D: coupling fault, a rising write to word 2 sets bit 0 of word 7 (bank 0)
    sa_on = 0;
    cp_on = 1; cp_bank = 0; cp_aggr = 2; cp_vict = 7;
    pulse_start(0, 0);
    wait_error(5000);
    check_eq("R10", "coupling err_addr", err_addr, 7);
    check_eq("R9", "coupling err_phase", err_phase, 1);
    check_eq("R9", "coupling err_found", err_found, 8'h01);
    check_eq("R9", "coupling err_picked", err_picked, 8'h01);
    check_eq("R9", "coupling err_dropped", err_dropped, 8'h00);
    check_eq("R11", "coupling err_reread", err_reread, 8'h01);
    check_halt_quiet("R11");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule